// File: doc/BRIEF.md
# Next Fetch Address Unit

This unit holds the instruction fetch address of a single-cycle processor and decides, on every enabled clock edge, where the next instruction comes from. The control decoder gives it a two-bit source select. It also receives the current instruction word and the value read from the source register. From these it forms one of four candidates: the next sequential word, a PC-relative branch target, a jump target inside the current 256 MB region, or a register-held address. It also presents the return address that link instructions write into the link register.

A two-state controller (RUN and HALTED) tracks whether the processor is still executing. Reset enters RUN and loads the boot vector 0xBFC00000. The single transition, ZERO_TARGET, goes from RUN to HALTED. It fires on an enabled edge whose chosen next address is 0x00000000. On that edge the fetch address becomes zero and the running flag drops. HALTED has no exit except reset, and in HALTED the fetch address is frozen.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, fetch_addr is 0xBFC00000 and running is 1.
- R2: With next_sel = 0 and step_en high in RUN, fetch_addr becomes fetch_addr + 4 on the clock edge.
- R3: With next_sel = 1, the new fetch_addr is fetch_addr + 4 plus instr_word[15:0], sign-extended and shifted left by two.
- R4: With next_sel = 2, the new fetch_addr is bits 31:28 of (fetch_addr + 4), then instr_word[25:0], then two zero bits.
- R5: With next_sel = 3, the new fetch_addr is rs_value.
- R6: link_addr equals fetch_addr + 8 in every cycle, with no register stage.
- R7: While step_en is low, fetch_addr and running keep their values whatever the other inputs are.
- R8: In RUN, an enabled edge whose selected next address is 0x00000000 loads fetch_addr with 0 and clears running on that same edge.
- R9: In HALTED, fetch_addr stays 0 and running stays 0 under any select, operands or enable until reset, and reset returns to RUN at the boot vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Clock enable for the fetch address and state |
| instr_word | input | 32 | Current instruction word |
| rs_value | input | 32 | Value of the source register |
| next_sel | input | 2 | Next address source: 0 sequential, 1 branch, 2 jump, 3 register |
| fetch_addr | output | 32 | Current instruction fetch address |
| link_addr | output | 32 | Return address, fetch_addr + 8 |
| running | output | 1 | 1 in RUN, 0 in HALTED |

## Verification
Several properties are checked on every clock. The sequential and register-target updates are checked, as are the hold under a low enable, the link offset, and the fact that HALTED is absorbing with the fetch address at zero. The arithmetic of the branch and jump targets is shown only by the bench scenarios. These cover forward and backward branch offsets and a jump whose region bits come from the incremented address after it crosses a region boundary. The ZERO_TARGET transition is also shown only by the bench, together with the later return to RUN through reset.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_JUMP   = 2'd2,
        SEL_REG    = 2'd3
    } nextpc_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } nextpc_state_e;

endpackage

// File: rtl/nextpc_target_calc.sv
module nextpc_target_calc #(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   pc_q,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [JIDX_W-1:0] jidx_field,
    input  logic [XLEN-1:0]   rs_value,
    output logic [XLEN-1:0]   seq_addr,
    output logic [XLEN-1:0]   branch_addr,
    output logic [XLEN-1:0]   jump_addr,
    output logic [XLEN-1:0]   reg_addr,
    output logic [XLEN-1:0]   link_addr
);
    localparam int REGION_W = XLEN - JIDX_W - 2;
    localparam int SEXT_W   = XLEN - IMM_W - 2;

    logic [XLEN-1:0] branch_off;

    always_comb begin
        seq_addr    = pc_q + XLEN'(4);
        link_addr   = pc_q + XLEN'(8);
        branch_off  = {{SEXT_W{imm_field[IMM_W-1]}}, imm_field, 2'b00};
        branch_addr = seq_addr + branch_off;
        jump_addr   = {seq_addr[XLEN-1 -: REGION_W], jidx_field, 2'b00};
        reg_addr    = rs_value;
    end

endmodule

// File: rtl/nextpc_select.sv
module nextpc_select
    import nextpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  nextpc_sel_e     sel,
    input  logic [XLEN-1:0] seq_addr,
    input  logic [XLEN-1:0] branch_addr,
    input  logic [XLEN-1:0] jump_addr,
    input  logic [XLEN-1:0] reg_addr,
    output logic [XLEN-1:0] cand_addr,
    output logic            cand_zero
);
    always_comb begin
        unique case (sel)
            SEL_SEQ:    cand_addr = seq_addr;
            SEL_BRANCH: cand_addr = branch_addr;
            SEL_JUMP:   cand_addr = jump_addr;
            SEL_REG:    cand_addr = reg_addr;
            default:    cand_addr = seq_addr;
        endcase
        cand_zero = (cand_addr == '0);
    end

endmodule

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
    import nextpc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_en,
    input  logic [XLEN-1:0] cand_addr,
    input  logic            cand_zero,
    output logic [XLEN-1:0] pc_q,
    output logic            running
);
    nextpc_state_e state_q, state_d;
    logic          advance;

    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                advance = step_en;
                if (step_en && cand_zero) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_VEC;
        end else if (advance) begin
            pc_q <= cand_addr;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  running = 1'b1;
            ST_HALT: running = 1'b0;
            default: running = 1'b0;
        endcase
    end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              IMM_W     = 16,
    parameter int              JIDX_W    = 26,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_en,
    input  logic [XLEN-1:0] instr_word,
    input  logic [XLEN-1:0] rs_value,
    input  logic [1:0]      next_sel,
    output logic [XLEN-1:0] fetch_addr,
    output logic [XLEN-1:0] link_addr,
    output logic            running
);
    logic [XLEN-1:0] seq_addr, branch_addr, jump_addr, reg_addr, cand_addr;
    logic            cand_zero;
    logic            unused_opcode_bits;

    assign unused_opcode_bits = ^instr_word[XLEN-1:JIDX_W];

    nextpc_target_calc #(
        .XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)
    ) calc_i (
        .pc_q       (fetch_addr),
        .imm_field  (instr_word[IMM_W-1:0]),
        .jidx_field (instr_word[JIDX_W-1:0]),
        .rs_value   (rs_value),
        .seq_addr   (seq_addr),
        .branch_addr(branch_addr),
        .jump_addr  (jump_addr),
        .reg_addr   (reg_addr),
        .link_addr  (link_addr)
    );

    nextpc_select #(.XLEN(XLEN)) sel_i (
        .sel        (nextpc_sel_e'(next_sel)),
        .seq_addr   (seq_addr),
        .branch_addr(branch_addr),
        .jump_addr  (jump_addr),
        .reg_addr   (reg_addr),
        .cand_addr  (cand_addr),
        .cand_zero  (cand_zero)
    );

    nextpc_ctrl #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .cand_addr(cand_addr),
        .cand_zero(cand_zero),
        .pc_q     (fetch_addr),
        .running  (running)
    );

endmodule

// File: rtl/nextpc_checker.sv
module nextpc_checker #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input logic            clk,
    input logic            rst,
    input logic            step_en,
    input logic [XLEN-1:0] rs_value,
    input logic [1:0]      next_sel,
    input logic [XLEN-1:0] fetch_addr,
    input logic [XLEN-1:0] link_addr,
    input logic            running
);
    p_boot_vec_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (fetch_addr == RESET_VEC) && running);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (running && step_en && next_sel == 2'd0 && fetch_addr != {XLEN{1'b1}} - XLEN'(3))
        |=> fetch_addr == $past(fetch_addr) + XLEN'(4));

    p_reg_target_r5: assert property (@(posedge clk) disable iff (rst)
        (running && step_en && next_sel == 2'd3)
        |=> fetch_addr == $past(rs_value));

    p_link_ofs_r6: assert property (@(posedge clk) disable iff (rst)
        link_addr == fetch_addr + XLEN'(8));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(fetch_addr) && $stable(running));

    p_halt_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !running |-> fetch_addr == '0);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !running |=> !running && $stable(fetch_addr));

endmodule

bind nextpc_unit nextpc_checker #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .rs_value  (rs_value),
    .next_sel  (next_sel),
    .fetch_addr(fetch_addr),
    .link_addr (link_addr),
    .running   (running)
);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] rs_value = '0;
    logic [1:0]  next_sel = '0;
    logic [31:0] fetch_addr, link_addr;
    logic        running;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_pc;

    always #10 clk = ~clk;

    nextpc_unit dut_i (
        .clk(clk), .rst(rst), .step_en(step_en), .instr_word(instr_word),
        .rs_value(rs_value), .next_sel(next_sel), .fetch_addr(fetch_addr),
        .link_addr(link_addr), .running(running)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 vector during reset", fetch_addr, 32'hBFC0_0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vector after reset", fetch_addr, 32'hBFC0_0000);
        check("R1 running after reset", {31'b0, running}, 32'd1);
        exp_pc = 32'hBFC0_0000;
    endtask

    task automatic step(input logic [1:0] sel, input logic [31:0] ins,
                        input logic [31:0] rs, input logic en);
        next_sel = sel; instr_word = ins; rs_value = rs; step_en = en;
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic t_sequential();
        for (int i = 0; i < 3; i++) begin
            step(2'd0, 32'hFFFF_FFFF, 32'h1234_5678, 1'b1);
            exp_pc = exp_pc + 32'd4;
            check("R2 sequential", fetch_addr, exp_pc);
        end
        check("R6 link", link_addr, exp_pc + 32'd8);
    endtask

    task automatic t_branch();
        step(2'd1, 32'h1234_0010, 32'h0, 1'b1);
        exp_pc = exp_pc + 32'd4 + 32'h40;
        check("R3 forward branch", fetch_addr, exp_pc);
        step(2'd1, 32'h0000_FFFE, 32'h0, 1'b1);
        exp_pc = exp_pc + 32'd4 - 32'd8;
        check("R3 backward branch", fetch_addr, exp_pc);
    endtask

    task automatic t_jump();
        step(2'd2, 32'h0812_3456, 32'h0, 1'b1);
        check("R4 jump in region", fetch_addr, 32'hB048_D158);
        step(2'd3, 32'h0, 32'h0FFF_FFFC, 1'b1);
        check("R5 register target", fetch_addr, 32'h0FFF_FFFC);
        check("R6 link", link_addr, 32'h1000_0004);
        step(2'd2, 32'hFC00_0010, 32'h0, 1'b1);
        check("R4 jump region from pc+4", fetch_addr, 32'h1000_0040);
        exp_pc = 32'h1000_0040;
    endtask

    task automatic t_hold();
        step(2'd3, 32'h0, 32'h1234_5678, 1'b0);
        check("R7 hold addr", fetch_addr, exp_pc);
        step(2'd3, 32'h0, 32'h0, 1'b0);
        check("R7 hold running", {31'b0, running}, 32'd1);
        check("R7 hold addr on zero target", fetch_addr, exp_pc);
        step(2'd3, 32'h0, 32'h0040_0020, 1'b1);
        check("R5 register target", fetch_addr, 32'h0040_0020);
    endtask

    task automatic t_halt();
        step(2'd3, 32'h0, 32'h0, 1'b1);
        check("R8 zero addr", fetch_addr, 32'h0);
        check("R8 running cleared", {31'b0, running}, 32'd0);
        step(2'd3, 32'h0, 32'h0000_1000, 1'b1);
        check("R9 halted addr reg", fetch_addr, 32'h0);
        step(2'd0, 32'h0, 32'h0, 1'b1);
        step(2'd1, 32'h0000_0100, 32'h0, 1'b1);
        check("R9 halted addr", fetch_addr, 32'h0);
        check("R9 halted flag", {31'b0, running}, 32'd0);
        check("R6 link halted", link_addr, 32'h8);
        do_reset();
        check("R9 reset leaves halt", {31'b0, running}, 32'd1);
    endtask

    initial begin
        do_reset();
        check("R6 link at vector", link_addr, 32'hBFC0_0008);
        t_sequential();
        t_branch();
        t_jump();
        t_hold();
        t_halt();
        t_sequential();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule